// File: doc/BRIEF.md
# Reset and Watchdog Supervisor

This block drives a processor's reset from a digital supply-good indication and guards the processor with a heartbeat watchdog. While the supply-good input is false, reset is asserted at once, with no clock needed. Once supply-good returns, reset stays asserted for a fixed number of clock ticks so the processor starts from a known state.

The watchdog looks for level changes on a heartbeat input. The heartbeat goes through a two-flop synchronizer before edges are detected. If no edge arrives within the watchdog window, the block drives its fault output low and issues one reset pulse of the same fixed length. The fault output then stays low until the next heartbeat edge. A select input picks a short or a long window. A separate input reports that the heartbeat line is floating. While it is set, the watchdog is switched off and the fault output is released.

Top module: `rst_wdog_supervisor`

## Requirements
- R1: While `pwr_ok` is 0, `rst_out_n` is 0 in the same cycle, through a combinational path.
- R2: After `pwr_ok` is first sampled high on a rising clock edge, `rst_out_n` stays 0 through that edge and the following RST_TICKS-1 edges, and it is 1 after edge number RST_TICKS.
- R3: `rst_out` is always the logical inverse of `rst_out_n`.
- R4: If no heartbeat edge is seen for the selected window of L ticks after the watchdog last restarted, `wd_fault_n` goes to 0 and `rst_out_n` goes to 0 on the same edge. The expiry falls on edge L counted from the restart edge.
- R5: A watchdog reset pulse lasts RST_TICKS cycles. `wd_fault_n` stays 0 after that pulse ends and until a heartbeat edge is detected.
- R6: While `hb_float` is 1, no watchdog timeout occurs and `wd_fault_n` is 1. A fault that is already set clears on the third rising edge after `hb_float` rises.
- R7: `wd_fast` = 1 selects the window WD_FAST_TICKS. `wd_fast` = 0 selects WD_SLOW_TICKS.
- R8: Each detected heartbeat edge restarts the watchdog. Edges spaced closer than the window keep both `rst_out_n` and `wd_fault_n` at 1 indefinitely.
- R9: The watchdog does not count while reset is asserted. It starts counting from zero on the edge where reset is released.
- R10: A change on `hb_level` takes effect on the third rising edge after it is applied, because of the two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the tick counters |
| rst_n | input | 1 | Asynchronous reset of the block's own flops, active low |
| pwr_ok | input | 1 | Supply-good flag, 1 when supply is valid |
| hb_level | input | 1 | Heartbeat level from the processor (asynchronous) |
| hb_float | input | 1 | 1 when the heartbeat line is unconnected |
| wd_fast | input | 1 | 1 selects the short watchdog window |
| rst_out_n | output | 1 | Processor reset, active low |
| rst_out | output | 1 | Processor reset, active high |
| wd_fault_n | output | 1 | Watchdog fault, active low |

## Verification
The bench measures the reset hold and the watchdog expiry to the exact cycle. An off-by-one counter therefore shows up as a reset that releases, or a fault that fires, one cycle early or late. The bench checks that the fault is still low after the watchdog reset pulse has ended. A design that cleared the fault together with reset would release it at that point. A heartbeat toggle is checked against the three-edge synchronizer latency, which catches a missing or extra stage. The bench also holds supply-good low for longer than the long window, then asserts the float input during a fault. These steps expose a watchdog that counts during reset, or that keeps running while the heartbeat line floats.

// File: rtl/rst_wdog_supervisor.sv
module rst_wdog_supervisor #(
  parameter int RST_TICKS     = 25_000_000,
  parameter int WD_FAST_TICKS = 12_500_000,
  parameter int WD_SLOW_TICKS = 200_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  input  logic hb_level,
  input  logic hb_float,
  input  logic wd_fast,
  output logic rst_out_n,
  output logic rst_out,
  output logic wd_fault_n
);

  localparam int WD_MAX = (WD_FAST_TICKS > WD_SLOW_TICKS) ? WD_FAST_TICKS : WD_SLOW_TICKS;
  localparam int RW = $clog2(RST_TICKS + 1);
  localparam int WW = $clog2(WD_MAX + 1);

  logic [2:0]    hb_q;
  logic [1:0]    fl_q;
  logic          rst_busy, fault;
  logic [RW-1:0] rst_cnt;
  logic [WW-1:0] wd_cnt, wd_lim;
  logic          hb_edge, wd_expire, float_s;

  assign float_s   = fl_q[1];
  assign hb_edge   = (hb_q[1] ^ hb_q[2]) & ~float_s;
  assign wd_lim    = wd_fast ? WW'(WD_FAST_TICKS - 1) : WW'(WD_SLOW_TICKS - 1);
  assign wd_expire = pwr_ok & ~rst_busy & ~float_s & ~hb_edge & (wd_cnt >= wd_lim);

  assign rst_out_n  = pwr_ok & ~rst_busy;
  assign rst_out    = ~rst_out_n;
  assign wd_fault_n = ~fault;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hb_q <= '0;
      fl_q <= '0;
    end else begin
      hb_q <= {hb_q[1:0], hb_level};
      fl_q <= {fl_q[0], hb_float};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rst_busy <= 1'b1;
      rst_cnt  <= '0;
    end else if (!pwr_ok || wd_expire) begin
      rst_busy <= 1'b1;
      rst_cnt  <= '0;
    end else if (rst_busy) begin
      if (rst_cnt == RW'(RST_TICKS - 1)) rst_busy <= 1'b0;
      else rst_cnt <= rst_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wd_cnt <= '0;
    else if (!pwr_ok || rst_busy || float_s || hb_edge || wd_expire) wd_cnt <= '0;
    else wd_cnt <= wd_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) fault <= 1'b0;
    else if (float_s || hb_edge) fault <= 1'b0;
    else if (wd_expire) fault <= 1'b1;

  a_r2_hold_on_return: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_ok && !$past(pwr_ok)) |-> !rst_out_n);

  a_r4_fault_brings_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_fault_n) |-> !rst_out_n);

  a_r5_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!wd_fault_n && !hb_edge && !float_s) |=> !wd_fault_n);

  a_r6_float_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (float_s && $past(float_s)) |-> wd_fault_n);

  a_r9_idle_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    rst_busy |=> (wd_cnt == '0));

endmodule

// File: tb/rst_wdog_supervisor_tb.sv
module rst_wdog_supervisor_tb;
  localparam int RT = 8, WF = 12, WS = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pwr_ok = 1'b0, hb_level = 1'b0, hb_float = 1'b0, wd_fast = 1'b0;
  logic rst_out_n, rst_out, wd_fault_n;

  rst_wdog_supervisor #(.RST_TICKS(RT), .WD_FAST_TICKS(WF), .WD_SLOW_TICKS(WS)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .hb_level(hb_level),
    .hb_float(hb_float), .wd_fast(wd_fast),
    .rst_out_n(rst_out_n), .rst_out(rst_out), .wd_fault_n(wd_fault_n));

  always #4 clk = ~clk;

  typedef struct { int due; bit is_fault; logic val; string tag; } exp_t;
  exp_t q[$];
  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(int dly, bit is_fault, logic val, string tag);
    exp_t e;
    e.due = cyc + dly; e.is_fault = is_fault; e.val = val; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    #2;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due <= cyc) begin
        logic act;
        act = q[i].is_fault ? wd_fault_n : rst_out_n;
        checks++;
        if (q[i].due < cyc || act !== q[i].val) begin
          errors++;
          $display("FAIL %s cyc %0d: %s actual %b expected %b", q[i].tag, cyc,
                   q[i].is_fault ? "wd_fault_n" : "rst_out_n", act, q[i].val);
        end
        if (!q[i].is_fault) begin
          checks++;
          if (rst_out !== ~rst_out_n) begin
            errors++;
            $display("FAIL R3 cyc %0d: rst_out actual %b expected %b", cyc, rst_out, ~rst_out_n);
          end
        end
        q.delete(i);
      end
    end
  end

  initial begin
    int c;
    step(3);
    rst_n = 1'b1;
    step(1);
    expect_at(0, 0, 1'b0, "R1 reset state");
    expect_at(0, 1, 1'b1, "R1 fault idle");
    step(WS + 6);
    expect_at(0, 0, 1'b0, "R9 held in reset");
    expect_at(0, 1, 1'b1, "R9 no count in reset");
    step(1);
    pwr_ok = 1'b1;
    expect_at(RT - 1, 0, 1'b0, "R2 hold last");
    expect_at(RT, 0, 1'b1, "R2 release");
    expect_at(RT + WS - 1, 1, 1'b1, "R4 before slow expiry");
    expect_at(RT + WS, 1, 1'b0, "R4 slow expiry fault");
    expect_at(RT + WS, 0, 1'b0, "R4 slow expiry reset");
    expect_at(RT + WS + RT - 1, 0, 1'b0, "R5 pulse last");
    expect_at(RT + WS + RT, 0, 1'b1, "R5 pulse end");
    expect_at(RT + WS + RT, 1, 1'b0, "R5 fault sticky");
    step(RT + WS + RT + 2);
    hb_level = ~hb_level;
    expect_at(2, 1, 1'b0, "R10 sync latency");
    expect_at(3, 1, 1'b1, "R5 edge clears fault");
    step(3);
    for (int k = 0; k < 12; k++) begin
      hb_level = ~hb_level;
      expect_at(0, 0, 1'b1, "R8 alive reset");
      expect_at(0, 1, 1'b1, "R8 alive fault");
      step(WS / 4);
    end
    wd_fast = 1'b1;
    hb_level = ~hb_level;
    expect_at(WF + 2, 1, 1'b1, "R7 before fast expiry");
    expect_at(WF + 3, 1, 1'b0, "R7 fast expiry");
    expect_at(WF + 3, 0, 1'b0, "R7 fast reset");
    step(WF + 3 + RT + 1);
    hb_float = 1'b1;
    expect_at(2, 1, 1'b0, "R6 float latency");
    expect_at(3, 1, 1'b1, "R6 float clears");
    step(3 * WS);
    expect_at(0, 1, 1'b1, "R6 no timeout floating");
    expect_at(0, 0, 1'b1, "R6 no reset floating");
    step(2);
    pwr_ok = 1'b0;
    expect_at(0, 0, 1'b0, "R1 immediate drop");
    step(4);
    pwr_ok = 1'b1;
    expect_at(RT - 1, 0, 1'b0, "R2 second hold");
    expect_at(RT, 0, 1'b1, "R2 second release");
    c = cyc;
    step(RT + 4);
    done = 1;
  end

  initial begin
    fork
      wait (done && q.size() == 0);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, pending %0d", q.size());
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule